// File: doc/BRIEF.md
# System Coprocessor Register File with Exception Return

This block holds the thirty-two 64-bit control registers of a processor's system coprocessor. The pipeline reaches it through a write port, a read port and an exception-return request. The write port carries the move-to operations and the read port carries the move-from operations, and each port has a narrow (32-bit) form and a wide (64-bit) form. Every read returns the stored value filtered through a mask that belongs to that register number. The processor-identity number reads as a constant. Every reserved register number is routed to one shared scratch cell. Software can change only the two software-interrupt bits of the Cause register.

An exception-return request selects the return address. If the error-level bit of Status is set, the address comes from the error return register. Otherwise it comes from the exception return register. The request clears the Status bit that made the choice, and on the next cycle the block presents the address with a one-cycle valid strobe so that the fetch unit can redirect. A small state machine has two states. ERT_IDLE has no strobe. ERT_STROBE holds eret_valid high for one cycle. The transition IDLE→STROBE and the transition STROBE→STROBE are both taken on a request. The transition STROBE→IDLE and the transition IDLE→IDLE are both taken when there is no request.

Top module: `sysctl_regfile`

## Requirements
- R1: A wide read of an implemented register returns the stored 64-bit value ANDed with that register's mask. The masks are:
  - 0: 0x8000003F
  - 1: 0x3F
  - 2 and 3: 0x7FFFFFFF
  - 4: 0xFFFFFFFFFFFFFFF0
  - 5: 0x01FFE000
  - 6, 8, 14, 20 and 30: all ones
  - 9, 11, 12 and 17: 0xFFFFFFFF
  - 10: 0xC00000FFFFFFE0FF
  - 13: 0xB000FFFF
  - 16: 0x7FFFFFFF
  - 18: 0xFFFFFFFB
  - 19: 0xF
  - 28: 0x0FFFFFC0
- R2: A narrow write (wr_wide=0) stores wr_data[31:0] with bit 31 copied into bits 63:32. A wide write stores all 64 bits.
- R3: Register numbers 7, 21, 22, 23, 24, 25 and 31 share one storage cell. A write to any of them is read back, unmasked, from all of them.
- R4: Register 15 always reads 0xB22, whatever has been written to it.
- R5: A write to register 13 (Cause) changes only bits 9 and 8. Every other bit of Cause keeps its value.
- R6: Registers 26, 27 and 29 always read zero.
- R7: A narrow read (rd_wide=0) returns bits 31:0 of the masked value, with bit 31 copied into bits 63:32.
- R8: Bits 63:32 of a wide read come from the stored value after masking, with no sign extension.
- R9: An exception return while Status (register 12) bit 2 is 1 clears Status bit 2. It also drives eret_valid high in the next cycle, with eret_pc equal to register 30.
- R10: An exception return while Status bit 2 is 0 clears Status bit 1. It also drives eret_valid high in the next cycle, with eret_pc equal to register 14.
- R11: A write takes effect at the clock edge that samples it. A read in the same cycle returns the old value. An exception return uses the register values from before that edge.
- R12: When an exception return and a write to Status arrive in the same cycle, the write to Status is dropped.
- R13: After reset, every register other than register 15 reads zero, and eret_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Move-to strobe |
| wr_wide | input | 1 | 1 = 64-bit move-to, 0 = 32-bit move-to |
| wr_sel | input | 5 | Register number written |
| wr_data | input | 64 | Write data |
| rd_sel | input | 5 | Register number read |
| rd_wide | input | 1 | 1 = 64-bit move-from, 0 = 32-bit move-from |
| rd_data | output | 64 | Combinational read result |
| eret_req | input | 1 | Exception-return command |
| eret_valid | output | 1 | One-cycle redirect strobe |
| eret_pc | output | 64 | Selected return address |

## Verification
A wrong stored value is visible on rd_data in the same cycle that it is selected, because the read port is combinational. A corrupted Status bit shows up as the wrong return address one cycle after the next exception-return request. A scratch cell that is not shared, or a Cause bit that leaks through, shows up the first time any alias number or Cause is read after the write. The bench compares rd_data and the strobe against a behavioural model on every cycle, so a fault is reported no later than the first read of the damaged register.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int XLEN       = 64;
    localparam int HALF       = XLEN / 2;
    localparam int NREGS      = 32;
    localparam int SEL_W      = $clog2(NREGS);
    localparam int IDX_SCR    = 7;
    localparam int IDX_STATUS = 12;
    localparam int IDX_CAUSE  = 13;
    localparam int IDX_EPC    = 14;
    localparam int IDX_PRID   = 15;
    localparam int IDX_ERREPC = 30;
    localparam int ST_ERL     = 2;
    localparam int ST_EXL     = 1;
    localparam int SWI_LO     = 8;
    localparam int SWI_HI     = 9;
    localparam logic [XLEN-1:0] PRID_CONST = 64'h0000_0000_0000_0B22;

    typedef enum logic {ERT_IDLE, ERT_STROBE} eret_state_e;

    function automatic logic is_reserved(input logic [SEL_W-1:0] s);
        return (s == 5'd7) || (s >= 5'd21 && s <= 5'd25) || (s == 5'd31);
    endfunction

    function automatic logic [XLEN-1:0] sext_half(input logic [XLEN-1:0] v);
        return {{HALF{v[HALF-1]}}, v[HALF-1:0]};
    endfunction

    function automatic logic [XLEN-1:0] read_mask(input logic [SEL_W-1:0] s);
        logic [XLEN-1:0] m;
        case (s)
            5'd0:  m = 64'h0000_0000_8000_003F;
            5'd1:  m = 64'h0000_0000_0000_003F;
            5'd2, 5'd3, 5'd16: m = 64'h0000_0000_7FFF_FFFF;
            5'd4:  m = 64'hFFFF_FFFF_FFFF_FFF0;
            5'd5:  m = 64'h0000_0000_01FF_E000;
            5'd6, 5'd8, 5'd14, 5'd20, 5'd30: m = '1;
            5'd9, 5'd11, 5'd12, 5'd17: m = 64'h0000_0000_FFFF_FFFF;
            5'd10: m = 64'hC000_00FF_FFFF_E0FF;
            5'd13: m = 64'h0000_0000_B000_FFFF;
            5'd15: m = 64'h0000_0000_0000_FFFF;
            5'd18: m = 64'h0000_0000_FFFF_FFFB;
            5'd19: m = 64'h0000_0000_0000_000F;
            5'd28: m = 64'h0000_0000_0FFF_FFC0;
            default: m = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/sysctl_wr_path.sv
module sysctl_wr_path
    import sysctl_pkg::*;
(
    input  logic             wr_en_i,
    input  logic             wr_wide_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [XLEN-1:0]  wr_data_i,
    input  logic [XLEN-1:0]  cause_q_i,
    output logic             wr_hit_o,
    output logic [SEL_W-1:0] wr_idx_o,
    output logic [XLEN-1:0]  wr_value_o
);
    logic [XLEN-1:0] ext;

    always_comb begin
        ext        = wr_wide_i ? wr_data_i : sext_half(wr_data_i);
        wr_hit_o   = wr_en_i;
        wr_idx_o   = is_reserved(wr_sel_i) ? SEL_W'(IDX_SCR) : wr_sel_i;
        wr_value_o = ext;
        if (wr_sel_i == SEL_W'(IDX_CAUSE)) begin
            wr_value_o = cause_q_i;
            wr_value_o[SWI_HI:SWI_LO] = ext[SWI_HI:SWI_LO];
        end
    end
endmodule

// File: rtl/sysctl_rd_path.sv
module sysctl_rd_path
    import sysctl_pkg::*;
(
    input  logic [XLEN-1:0]  regs_i [NREGS],
    input  logic [SEL_W-1:0] rd_sel_i,
    input  logic             rd_wide_i,
    output logic [XLEN-1:0]  rd_data_o
);
    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] filt;

    always_comb begin
        if (is_reserved(rd_sel_i)) begin
            raw  = regs_i[IDX_SCR];
            filt = raw;
        end else begin
            raw  = regs_i[rd_sel_i];
            filt = raw & read_mask(rd_sel_i);
        end
        if (rd_sel_i == SEL_W'(IDX_PRID))
            filt = PRID_CONST;
        rd_data_o = rd_wide_i ? filt : sext_half(filt);
    end
endmodule

// File: rtl/sysctl_eret_fsm.sv
module sysctl_eret_fsm
    import sysctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            eret_req_i,
    input  logic [XLEN-1:0] status_i,
    input  logic [XLEN-1:0] epc_i,
    input  logic [XLEN-1:0] errepc_i,
    output logic [XLEN-1:0] status_clr_o,
    output logic            eret_valid_o,
    output logic [XLEN-1:0] eret_pc_o
);
    eret_state_e state_q, state_d;
    logic [XLEN-1:0] pc_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ERT_IDLE:   state_d = eret_req_i ? ERT_STROBE : ERT_IDLE;
            ERT_STROBE: state_d = eret_req_i ? ERT_STROBE : ERT_IDLE;
            default:    state_d = ERT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ERT_IDLE;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (eret_req_i)
                pc_q <= status_i[ST_ERL] ? errepc_i : epc_i;
        end
    end

    always_comb begin
        status_clr_o = '0;
        if (eret_req_i) begin
            if (status_i[ST_ERL]) status_clr_o[ST_ERL] = 1'b1;
            else                  status_clr_o[ST_EXL] = 1'b1;
        end
        eret_valid_o = (state_q == ERT_STROBE);
        eret_pc_o    = pc_q;
    end

    AST_STROBE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        eret_valid_o |-> $past(eret_req_i)); // R9
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_wide,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    input  logic             rd_wide,
    output logic [XLEN-1:0]  rd_data,
    input  logic             eret_req,
    output logic             eret_valid,
    output logic [XLEN-1:0]  eret_pc
);
    logic [XLEN-1:0]  regs_q [NREGS];
    logic             wr_hit;
    logic [SEL_W-1:0] wr_idx;
    logic [XLEN-1:0]  wr_value;
    logic [XLEN-1:0]  status_clr;
    logic [XLEN-1:0]  status_q;
    logic [XLEN-1:0]  cause_q;

    assign status_q = regs_q[IDX_STATUS];
    assign cause_q  = regs_q[IDX_CAUSE];

    sysctl_wr_path u_wr (
        .wr_en_i    (wr_en),
        .wr_wide_i  (wr_wide),
        .wr_sel_i   (wr_sel),
        .wr_data_i  (wr_data),
        .cause_q_i  (cause_q),
        .wr_hit_o   (wr_hit),
        .wr_idx_o   (wr_idx),
        .wr_value_o (wr_value)
    );

    sysctl_rd_path u_rd (
        .regs_i    (regs_q),
        .rd_sel_i  (rd_sel),
        .rd_wide_i (rd_wide),
        .rd_data_o (rd_data)
    );

    sysctl_eret_fsm u_eret (
        .clk          (clk),
        .rst_n        (rst_n),
        .eret_req_i   (eret_req),
        .status_i     (status_q),
        .epc_i        (regs_q[IDX_EPC]),
        .errepc_i     (regs_q[IDX_ERREPC]),
        .status_clr_o (status_clr),
        .eret_valid_o (eret_valid),
        .eret_pc_o    (eret_pc)
    );

    for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
        if (is_reserved(SEL_W'(gi)) && gi != IDX_SCR) begin : g_alias
            assign regs_q[gi] = '0;
        end else if (gi == IDX_STATUS) begin : g_status
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[gi] <= '0;
                else if (eret_req)
                    regs_q[gi] <= regs_q[gi] & ~status_clr;
                else if (wr_hit && wr_idx == SEL_W'(gi))
                    regs_q[gi] <= wr_value;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs_q[gi] <= '0;
                else if (wr_hit && wr_idx == SEL_W'(gi))
                    regs_q[gi] <= wr_value;
            end
        end
    end

    AST_CAUSE_OTHER_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_W'(IDX_CAUSE)) |=>
        (cause_q[7:0] == $past(cause_q[7:0]) && cause_q[XLEN-1:10] == $past(cause_q[XLEN-1:10]))); // R5
    AST_ERL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_req && status_q[ST_ERL]) |=> !status_q[ST_ERL]); // R9
    AST_EXL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_req && !status_q[ST_ERL]) |=> !status_q[ST_EXL]); // R10
    AST_ZERO_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 5'd26 || rd_sel == 5'd27 || rd_sel == 5'd29) |-> rd_data == '0); // R6
    AST_NARROW_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_wide |-> rd_data[XLEN-1:HALF] == {HALF{rd_data[HALF-1]}}); // R7
endmodule

// File: tb/sysctl_regfile_tb.sv
module sysctl_regfile_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_wide = 1'b0, rd_wide = 1'b1, eret_req = 1'b0;
    logic [4:0]  wr_sel = '0, rd_sel = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data, eret_pc;
    logic        eret_valid;

    int checks = 0, failures = 0;
    logic [63:0] m_regs [32];
    logic        exp_valid = 1'b0;
    logic [63:0] exp_pc = '0;
    string       exp_tag = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_wide(rd_wide), .rd_data(rd_data),
        .eret_req(eret_req), .eret_valid(eret_valid), .eret_pc(eret_pc)
    );

    function automatic bit alias_num(int s);
        return s == 7 || (s >= 21 && s <= 25) || s == 31;
    endfunction

    function automatic logic [63:0] spec_mask(int s);
        case (s)
            0: return 64'h8000003F;
            1: return 64'h3F;
            2, 3, 16: return 64'h7FFFFFFF;
            4: return 64'hFFFFFFFFFFFFFFF0;
            5: return 64'h01FFE000;
            6, 8, 14, 20, 30: return {64{1'b1}};
            9, 11, 12, 17: return 64'hFFFFFFFF;
            10: return 64'hC00000FFFFFFE0FF;
            13: return 64'hB000FFFF;
            18: return 64'hFFFFFFFB;
            19: return 64'hF;
            28: return 64'h0FFFFFC0;
            default: return 64'h0;
        endcase
    endfunction

    function automatic logic [63:0] to64(logic [63:0] v);
        return {{32{v[31]}}, v[31:0]};
    endfunction

    function automatic logic [63:0] m_read(int s, bit wide);
        logic [63:0] v;
        if (s == 15) v = 64'hB22;
        else if (alias_num(s)) v = m_regs[7];
        else v = m_regs[s] & spec_mask(s);
        return wide ? v : to64(v);
    endfunction

    function automatic string tag_of(int s, bit wide);
        if (s == 15) return "R4";
        if (alias_num(s)) return "R3";
        if (s == 26 || s == 27 || s == 29) return "R6";
        return wide ? "R1/R8" : "R7";
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(bit we, bit ww, int ws, logic [63:0] wd, int rs, bit rw, bit er, string note);
        logic [63:0] v;
        int idx;
        wr_en = we; wr_wide = ww; wr_sel = 5'(ws); wr_data = wd;
        rd_sel = 5'(rs); rd_wide = rw; eret_req = er;
        #1;
        chk((we && ws == rs) ? "R11" : (note != "" ? note : tag_of(rs, rw)), rd_data, m_read(rs, rw));
        chk(exp_tag, {63'd0, eret_valid}, {63'd0, exp_valid});
        if (exp_valid) chk(exp_tag, eret_pc, exp_pc);
        @(posedge clk);
        exp_valid = er;
        if (er) begin
            exp_tag = m_regs[12][2] ? "R9" : "R10";
            exp_pc  = m_regs[12][2] ? m_regs[30] : m_regs[14];
        end
        if (we) begin
            v = ww ? wd : to64(wd);
            idx = alias_num(ws) ? 7 : ws;
            if (ws == 13) m_regs[13][9:8] = v[9:8];
            else if (!(er && idx == 12)) m_regs[idx] = v;
        end
        if (er) begin
            if (m_regs[12][2]) m_regs[12][2] = 1'b0;
            else m_regs[12][1] = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic scan(string note);
        wr_en = 0; eret_req = 0;
        for (int s = 0; s < 32; s++) begin
            for (int w = 0; w < 2; w++) begin
                rd_sel = 5'(s); rd_wide = w[0];
                #1;
                chk(note != "" ? note : tag_of(s, w[0]), rd_data, m_read(s, w[0]));
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) m_regs[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R13: reset state
        scan("");
        chk("R13", {63'd0, eret_valid}, 64'd0);
        // R1 R7 R8: every register written with all ones, then read both widths
        for (int s = 0; s < 32; s++) step(1, 1, s, {64{1'b1}}, 0, 1, 0, "");
        scan("");
        // R2: narrow write sign extension
        step(1, 0, 14, 64'h12345678_80000000, 14, 1, 0, "");
        step(0, 0, 0, 0, 14, 1, 0, "R2");
        chk("R2", rd_data, 64'hFFFFFFFF_80000000);
        step(1, 0, 8, 64'hFFFFFFFF_00001234, 8, 1, 0, "");
        step(0, 0, 0, 0, 8, 1, 0, "R2");
        // R3: alias sharing
        step(1, 1, 22, 64'hA5A5_0000_1111_2222, 7, 1, 0, "");
        step(0, 0, 0, 0, 31, 1, 0, "R3");
        chk("R3", rd_data, 64'hA5A5_0000_1111_2222);
        step(0, 0, 0, 0, 25, 0, 0, "R3");
        // R5: Cause
        step(1, 1, 13, 64'h0, 13, 1, 0, "");
        step(1, 1, 13, {64{1'b1}}, 13, 1, 0, "R5");
        step(0, 0, 0, 0, 13, 1, 0, "R5");
        chk("R5", rd_data, 64'h300);
        // R4 R6
        step(1, 1, 15, 64'h5555, 15, 1, 0, "");
        step(1, 1, 27, 64'h7777, 15, 1, 0, "R4");
        step(0, 0, 0, 0, 27, 1, 0, "R6");
        // R11: same-cycle read returns old
        step(1, 1, 17, 64'h0000_0000_CAFE_F00D, 17, 1, 0, "R11");
        step(0, 0, 0, 0, 17, 1, 0, "R11");
        // R9 R10: exception return
        step(1, 1, 30, 64'h0000_0000_BFC0_0100, 0, 1, 0, "");
        step(1, 1, 14, 64'h0000_0000_8000_0200, 0, 1, 0, "");
        step(1, 1, 12, 64'h6, 12, 1, 0, "");
        step(0, 0, 0, 0, 12, 1, 1, "R9");
        step(0, 0, 0, 0, 12, 1, 0, "R9");
        chk("R9", eret_pc, 64'h0000_0000_BFC0_0100);
        step(0, 0, 0, 0, 12, 1, 1, "R10");
        step(0, 0, 0, 0, 12, 1, 0, "R10");
        chk("R10", eret_pc, 64'h0000_0000_8000_0200);
        // R12: eret with simultaneous Status write
        step(1, 1, 12, 64'h2, 0, 1, 0, "");
        step(1, 1, 12, 64'hF0, 12, 1, 1, "R12");
        step(0, 0, 0, 0, 12, 1, 0, "R12");
        chk("R12", rd_data, 64'h0);
        // mixed traffic
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 31),
                 {$urandom, $urandom}, $urandom_range(0, 31), $urandom_range(0, 1),
                 ($urandom_range(0, 9) == 0), "");
        end
        scan("");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule